// File: doc/BRIEF.md
# Multiplexed Bus Cycle Sequencer

This block sits between a small 8-bit processor core and its external bus. The core hands it one transfer at a time. A transfer is a memory or I/O access, either read or write, with a 16-bit address and a write byte. The sequencer then runs a single machine cycle made of T-states, and each T-state is one clock period long.

The low address byte and the data byte share one set of lines. The low address appears on those lines only in T1, and a latch-enable strobe marks it so that outside logic can capture it. The high address byte has its own dedicated pins. A select output tells the outside world whether the cycle is a memory cycle (low) or an I/O cycle (high). Active-low read and write strobes frame the data phase.

A slow device can hold the ready input low to stretch the cycle with wait states. When the cycle ends, the captured read byte is presented to the core together with a one-clock done pulse. The shared lines are brought out as separate output, output-enable and input ports, and the pad ring combines them.

Top module: `mux_bus_seq`

## Requirements
- R1: After reset the sequencer is idle: `req_ready`=1, `ale`=0, `rd_n`=1, `wr_n`=1, `ad_oe`=0, `done`=0.
- R2: A request is taken on a clock edge where `req_valid`=1 and `req_ready`=1. In the next clock (T1), `ale`=1, `ad_oe`=1 and `ad_o` carries address bits 7:0. `ale` is high for exactly that one clock, and T2 always follows T1.
- R3: `io_m` is 0 for the whole of a memory cycle and 1 for the whole of an I/O cycle. For memory cycles, `addr_hi` carries address bits 15:8 from T1 until the last T-state.
- R4: In an I/O cycle, request address bits 7:0 are the port number. They appear on both `ad_o` (in T1) and `addr_hi`.
- R5: In a read cycle, `rd_n` is 0 from T2 through T3 and `ad_oe` is 0 throughout that span. `wr_n` stays 1.
- R6: In a write cycle, `wr_n` is 0 from T2 through T3, and `ad_oe`=1 with `ad_o` equal to the write byte over that span. `rd_n` stays 1.
- R7: `ready` is sampled at the end of T2 and at the end of each wait state. Each sample taken low adds exactly one wait clock. With no waits the cycle is T1, T2, T3 (three clocks).
- R8: `rd_data` takes the value on `ad_i` at the clock edge that ends T3 of a read cycle. It keeps that value across later write cycles.
- R9: `done` is 1 for exactly the one clock after T3. In that clock `req_ready` is 1 and both strobes are inactive.
- R10: A request presented while a cycle is in progress is ignored. The running cycle's address outputs do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one T-state per period |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Core presents a transfer |
| req_io | input | 1 | 1 = I/O transfer, 0 = memory |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Transfer address (bits 7:0 = port for I/O) |
| req_wdata | input | 8 | Write byte |
| req_ready | output | 1 | Sequencer idle, request can be taken |
| done | output | 1 | One-clock completion pulse |
| rd_data | output | 8 | Byte captured in a read cycle |
| ad_o | output | 8 | Shared low-address/data lines, outgoing value |
| ad_oe | output | 1 | Drive enable for the shared lines |
| ad_i | input | 8 | Shared lines, incoming value |
| addr_hi | output | 8 | High address byte |
| ale | output | 1 | Low-address latch strobe (T1) |
| io_m | output | 1 | 0 = memory cycle, 1 = I/O cycle |
| rd_n | output | 1 | Active-low read strobe |
| wr_n | output | 1 | Active-low write strobe |
| ready | input | 1 | Device ready; low inserts wait states |

## Verification
The hardest situation to reach is a long wait stretch in which `ready` changes exactly at the sampling point. The read capture edge has to be separated from the clocks just before it. The stimulus steers `ready` one clock at a time, driving it low at the end of T2 and then through a chosen number of wait clocks. In that same pass it drives the complement of the read byte onto `ad_i` during every clock except T3. A capture taken one edge early or late therefore yields a visibly wrong byte, and a miscounted wait shows up as a shifted `done` pulse.

// File: rtl/mbs_pkg.sv
package mbs_pkg;
  typedef enum logic [2:0] {
    TS_IDLE = 3'd0,
    TS_T1   = 3'd1,
    TS_T2   = 3'd2,
    TS_TW   = 3'd3,
    TS_T3   = 3'd4
  } tstate_e;
endpackage

// File: rtl/mbs_tstate_fsm.sv
module mbs_tstate_fsm
  import mbs_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    start,
  input  logic    ready,
  output tstate_e state,
  output logic    done
);
  tstate_e state_q, state_d;
  logic    done_q, done_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      TS_IDLE: if (start) state_d = TS_T1;
      TS_T1:   state_d = TS_T2;
      TS_T2:   state_d = ready ? TS_T3 : TS_TW;
      TS_TW:   state_d = ready ? TS_T3 : TS_TW;
      TS_T3:   state_d = TS_IDLE;
      default: state_d = TS_IDLE;
    endcase
    done_d = (state_q == TS_T3);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= TS_IDLE;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
    end
  end

  assign state = state_q;
  assign done  = done_q;

  AST_T1_THEN_T2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == TS_T1) |=> (state_q == TS_T2)); // R2
  AST_WAIT_ON_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == TS_T2 || state_q == TS_TW) && !ready) |=> (state_q == TS_TW)); // R7
  AST_LEAVE_WAIT_ON_READY: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == TS_T2 || state_q == TS_TW) && ready) |=> (state_q == TS_T3)); // R7
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q); // R9
endmodule

// File: rtl/mbs_pin_drive.sv
module mbs_pin_drive
  import mbs_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          req_io,
  input  logic          req_wr,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  input  tstate_e       state,
  input  logic [DW-1:0] ad_i,
  output logic [DW-1:0] ad_o,
  output logic          ad_oe,
  output logic [AW-DW-1:0] addr_hi,
  output logic          ale,
  output logic          io_m,
  output logic          rd_n,
  output logic          wr_n,
  output logic [DW-1:0] rd_data
);
  localparam int HW = AW - DW;

  logic          io_q, wr_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] wdata_q, rdata_q;
  logic          cap_en;
  logic [HW-1:0] hi_eff;
  logic          active, addr_phase, data_phase;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      io_q    <= 1'b0;
      wr_q    <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (start) begin
      io_q    <= req_io;
      wr_q    <= req_wr;
      addr_q  <= req_addr;
      wdata_q <= req_wdata;
    end
  end

  assign cap_en = (state == TS_T3) && !wr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rdata_q <= '0;
    else if (cap_en) rdata_q <= ad_i;
  end

  always_comb begin
    active     = (state != TS_IDLE);
    addr_phase = (state == TS_T1);
    data_phase = (state == TS_T2) || (state == TS_TW) || (state == TS_T3);
    hi_eff     = io_q ? HW'(addr_q[DW-1:0]) : addr_q[AW-1:DW];
    ale        = addr_phase;
    io_m       = active && io_q;
    addr_hi    = active ? hi_eff : '0;
    ad_oe      = addr_phase || (data_phase && wr_q);
    if (addr_phase)            ad_o = addr_q[DW-1:0];
    else if (data_phase && wr_q) ad_o = wdata_q;
    else                       ad_o = '0;
    rd_n       = !(data_phase && !wr_q);
    wr_n       = !(data_phase && wr_q);
  end

  assign rd_data = rdata_q;

  AST_READ_BUS_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_n |-> !ad_oe); // R5
  AST_STROBES_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(!rd_n && !wr_n)); // R5
  AST_ALE_ONE_CLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    ale |=> !ale); // R2
endmodule

// File: rtl/mux_bus_seq.sv
module mux_bus_seq
  import mbs_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          req_io,
  input  logic          req_wr,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          req_ready,
  output logic          done,
  output logic [DW-1:0] rd_data,
  output logic [DW-1:0] ad_o,
  output logic          ad_oe,
  input  logic [DW-1:0] ad_i,
  output logic [AW-DW-1:0] addr_hi,
  output logic          ale,
  output logic          io_m,
  output logic          rd_n,
  output logic          wr_n,
  input  logic          ready
);
  logic [1:0] rst_sync_q;
  logic       rst_int_n;
  tstate_e    state;
  logic       start;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  assign req_ready = (state == TS_IDLE);
  assign start     = req_valid && req_ready;

  mbs_tstate_fsm i_fsm (
    .clk   (clk),
    .rst_n (rst_int_n),
    .start (start),
    .ready (ready),
    .state (state),
    .done  (done)
  );

  mbs_pin_drive #(.AW(AW), .DW(DW)) i_pins (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .start     (start),
    .req_io    (req_io),
    .req_wr    (req_wr),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .state     (state),
    .ad_i      (ad_i),
    .ad_o      (ad_o),
    .ad_oe     (ad_oe),
    .addr_hi   (addr_hi),
    .ale       (ale),
    .io_m      (io_m),
    .rd_n      (rd_n),
    .wr_n      (wr_n),
    .rd_data   (rd_data)
  );

  AST_CAPTURE_AT_T3_END: assert property (@(posedge clk) disable iff (!rst_int_n)
    (done && !$past(rd_n)) |-> (rd_data == $past(ad_i))); // R8
  AST_CYCLE_TYPE_STABLE: assert property (@(posedge clk) disable iff (!rst_int_n)
    (!req_ready && !ale) |-> ($stable(io_m) && $stable(addr_hi))); // R3
  AST_BUSY_NO_ACCEPT: assert property (@(posedge clk) disable iff (!rst_int_n)
    (!req_ready && req_valid) |=> !ale); // R10
endmodule

// File: tb/test_mux_bus_seq.sv
module test_mux_bus_seq;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_io, req_wr;
  logic [15:0] req_addr;
  logic [7:0]  req_wdata, ad_i;
  logic        ready;
  logic        req_ready, done, ad_oe, ale, io_m, rd_n, wr_n;
  logic [7:0]  rd_data, ad_o, addr_hi;

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 0;
  logic [7:0] last_rd = 8'h00;

  always #2 clk = ~clk;

  mux_bus_seq i_mux_bus_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_io(req_io),
    .req_wr(req_wr), .req_addr(req_addr), .req_wdata(req_wdata),
    .req_ready(req_ready), .done(done), .rd_data(rd_data), .ad_o(ad_o),
    .ad_oe(ad_oe), .ad_i(ad_i), .addr_hi(addr_hi), .ale(ale), .io_m(io_m),
    .rd_n(rd_n), .wr_n(wr_n), .ready(ready)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // io, wr, addr, wdata, rdata, waits
  localparam int NV = 6;
  localparam logic [36:0] VEC [NV] = '{
    {1'b0, 1'b0, 16'h1234, 8'h00, 8'hA5, 3'd0},
    {1'b0, 1'b1, 16'hBEEF, 8'h3C, 8'h00, 3'd0},
    {1'b1, 1'b0, 16'hAA7F, 8'h00, 8'h5A, 3'd2},
    {1'b1, 1'b1, 16'h0081, 8'hC3, 8'h00, 3'd1},
    {1'b0, 1'b0, 16'hFF00, 8'h00, 8'h96, 3'd4},
    {1'b0, 1'b1, 16'h0001, 8'hFF, 8'h00, 3'd3}
  };

  task automatic data_phase_check(input logic io, input logic wr, input logic [7:0] hi,
                                  input logic [7:0] wd);
    check("R2 ale low after T1", {31'd0, ale}, 32'd0);
    check("R3 io_m held", {31'd0, io_m}, {31'd0, io});
    check("R3 addr_hi held", {24'd0, addr_hi}, {24'd0, hi});
    if (wr) begin
      check("R6 wr_n low", {31'd0, wr_n}, 32'd0);
      check("R6 rd_n high", {31'd0, rd_n}, 32'd1);
      check("R6 bus driven", {31'd0, ad_oe}, 32'd1);
      check("R6 write data", {24'd0, ad_o}, {24'd0, wd});
    end else begin
      check("R5 rd_n low", {31'd0, rd_n}, 32'd0);
      check("R5 wr_n high", {31'd0, wr_n}, 32'd1);
      check("R5 bus released", {31'd0, ad_oe}, 32'd0);
    end
  endtask

  task automatic run_cycle(input logic io, input logic wr, input logic [15:0] addr,
                           input logic [7:0] wd, input logic [7:0] rdv,
                           input int waits, input bit hold_busy);
    logic [7:0] hi;
    hi = io ? addr[7:0] : addr[15:8];
    check("R2 idle before request", {31'd0, req_ready}, 32'd1);
    req_valid = 1'b1; req_io = io; req_wr = wr; req_addr = addr; req_wdata = wd;
    ad_i = ~rdv; ready = 1'b1;
    @(negedge clk); // T1
    check("R2 ale in T1", {31'd0, ale}, 32'd1);
    check("R2 bus driven in T1", {31'd0, ad_oe}, 32'd1);
    check("R4 R2 low address", {24'd0, ad_o}, {24'd0, addr[7:0]});
    check("R4 R3 high address", {24'd0, addr_hi}, {24'd0, hi});
    check("R3 io_m", {31'd0, io_m}, {31'd0, io});
    check("R5 R6 strobes idle in T1", {30'd0, rd_n, wr_n}, 32'd3);
    if (hold_busy) begin
      req_addr = 16'h5566; req_io = ~io; req_wr = ~wr;
    end else req_valid = 1'b0;
    @(negedge clk); // T2
    data_phase_check(io, wr, hi, wd);
    ready = (waits == 0);
    for (int i = 0; i < waits; i++) begin
      @(negedge clk); // wait state
      data_phase_check(io, wr, hi, wd);
      check("R7 no done during wait", {31'd0, done}, 32'd0);
      ready = (i == waits - 1);
    end
    @(negedge clk); // T3
    data_phase_check(io, wr, hi, wd);
    check("R7 no done in T3", {31'd0, done}, 32'd0);
    check("R10 still busy", {31'd0, req_ready}, 32'd0);
    ad_i = rdv; req_valid = 1'b0;
    @(negedge clk); // done clock
    ad_i = ~rdv;
    check("R9 done pulse", {31'd0, done}, 32'd1);
    check("R9 ready for next", {31'd0, req_ready}, 32'd1);
    check("R9 strobes inactive", {30'd0, rd_n, wr_n}, 32'd3);
    if (!wr) last_rd = rdv;
    check("R8 read data", {24'd0, rd_data}, {24'd0, last_rd});
    @(negedge clk);
    check("R9 done one clock", {31'd0, done}, 32'd0);
    check("R10 no extra cycle", {31'd0, ale}, 32'd0);
  endtask

  initial begin
    #(4 * 200000);
    if (!finished) begin
      n_fail++; n_tests++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_io = 1'b0; req_wr = 1'b0;
    req_addr = '0; req_wdata = '0; ad_i = '0; ready = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 req_ready", {31'd0, req_ready}, 32'd1);
    check("R1 ale", {31'd0, ale}, 32'd0);
    check("R1 strobes", {30'd0, rd_n, wr_n}, 32'd3);
    check("R1 ad_oe", {31'd0, ad_oe}, 32'd0);
    check("R1 done", {31'd0, done}, 32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 idle after release", {31'd0, req_ready}, 32'd1);

    for (int v = 0; v < NV; v++) begin
      run_cycle(VEC[v][36], VEC[v][35], VEC[v][34:19], VEC[v][18:11],
                VEC[v][10:3], int'(VEC[v][2:0]), 1'b0);
    end

    // R10: request held with other fields while busy
    run_cycle(1'b0, 1'b0, 16'h9ABC, 8'h00, 8'h3E, 1, 1'b1);
    // R8: write with long wait keeps prior read data
    run_cycle(1'b0, 1'b1, 16'h4321, 8'h77, 8'h00, 5, 1'b0);
    // R7: stretched read, seven wait clocks
    run_cycle(1'b1, 1'b0, 16'h00F0, 8'h00, 8'hE1, 7, 1'b0);

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule